// File: doc/BRIEF.md
# Multi-Source Level Interrupt Aggregator

This block merges eight peripheral event lines into a single maskable interrupt for a small processor. Each event pulse sets a bit in a pending register. Software picks which of those bits may raise the interrupt through a mask register. A request flag is formed continuously from the two registers. It is never latched, so it falls as soon as no bit is both pending and allowed.

A priority field, a global interrupt flag and the processor's current level then gate that flag. The result is the line sent to the core. The core's acknowledge touches neither the flag nor any pending bit. The service routine reads the pending register to find the cause, and it clears bits by writing 0 to their positions.

Registers sit on a simple bus with a 2-bit word address. Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `irq_aggregator`

## Requirements
- R1: The request flag (`req`, and bit 3 of the control word at address 2) is 1 whenever some bit position is 1 in both the pending register (address 0) and the mask register (address 1).
- R2: The request flag is 0 whenever no position has both bits at 1, in the same cycle that condition arises. A request that was not serviced is not held.
- R3: Bit 3 of a write to the control word (address 2) is ignored, so writing 0 there does not lower the request flag. Bits 2:0 of that write set the priority level.
- R4: A pulse on `ack` leaves every pending bit unchanged.
- R5: A pulse on `ack` leaves the request flag unchanged.
- R6: While the request flag is 1, a further enabled source becoming pending keeps it at 1 on every cycle, with no drop.
- R7: `cpu_irq` is 1 exactly when `gie` is 1, the request flag is 1, and the priority level is strictly greater than `cpu_level`. A level of 0 therefore never raises `cpu_irq`.
- R8: Writing the pending register clears each position written as 0 and leaves each position written as 1 unchanged. An event in the same cycle as a clear of its position leaves the bit at 1.
- R9: Reset clears the pending register, the mask register and the priority level, so the request flag and `cpu_irq` are 0.
- R10: An event pulse sets its pending bit at the next clock edge whether or not the bit is masked. Software can read the pending bits back at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt | input | 8 | One-cycle event pulses, one per source |
| bus_addr | input | 2 | Word address: 0 pending, 1 mask, 2 control |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (0 at address 3) |
| gie | input | 1 | Global interrupt enable flag from the core |
| cpu_level | input | 3 | Core's current priority level |
| ack | input | 1 | Interrupt acknowledge from the core |
| req | output | 1 | Non-latched request flag |
| cpu_irq | output | 1 | Gated interrupt request to the core |

## Verification
The hardest case to reach from the ports is a clear of a pending bit in the same cycle as a new event on that bit. A second hard case is a new enabled source arriving while the request is already high, where any one-cycle dip must be caught. The stimulus drives the event and the bus write in the same clock period and then reads back the pending register. For the second case, the bench samples the request flag on every cycle around the arrival of the second source. Then the bench clears the sources one at a time and checks that the request flag falls in the same cycle as the last clear.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NSRC = 8,
  parameter int LVLW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [1:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  input  logic            gie,
  input  logic [LVLW-1:0] cpu_level,
  input  logic            ack,
  output logic            req,
  output logic            cpu_irq
);
  localparam logic [1:0] A_PEND = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  logic [NSRC-1:0] pend, mask, clr;
  logic [LVLW-1:0] lvl;
  logic            ack_unused;

  assign ack_unused = ack;
  assign clr = (bus_wr && bus_addr == A_PEND) ? ~bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend <= '0;
      mask <= '0;
      lvl  <= '0;
    end else begin
      pend <= (pend & ~clr) | evt;
      if (bus_wr && bus_addr == A_MASK) mask <= bus_wdata;
      if (bus_wr && bus_addr == A_CTRL) lvl  <= bus_wdata[LVLW-1:0];
    end

  assign req     = |(pend & mask);
  assign cpu_irq = gie && req && (lvl != '0) && (lvl > cpu_level);

  always_comb
    case (bus_addr)
      A_PEND:  bus_rdata = pend;
      A_MASK:  bus_rdata = mask;
      A_CTRL:  bus_rdata = NSRC'({req, lvl});
      default: bus_rdata = '0;
    endcase
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NSRC = 8,
  parameter int LVLW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt,
  input logic [1:0]      bus_addr,
  input logic            bus_wr,
  input logic [NSRC-1:0] bus_wdata,
  input logic            gie,
  input logic [LVLW-1:0] cpu_level,
  input logic            ack,
  input logic            req,
  input logic            cpu_irq,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] mask,
  input logic [LVLW-1:0] lvl
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0; else past_ok <= 1'b1;

  AST_EVT_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & mask) && !(bus_wr && bus_addr == 2'd1)) |=> req); // R1
  AST_ACK_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ack && !bus_wr) |=> ((pend & $past(pend)) == $past(pend))); // R4
  AST_ACK_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ack && req && !bus_wr) |=> req); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (gie && req && lvl > cpu_level)); // R7
  AST_LVL_ZERO_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == '0) |-> !cpu_irq); // R7
  AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && evt == '0) |=> ((pend & ~$past(bus_wdata)) == '0)); // R8
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((pend & $past(evt)) == $past(evt))); // R10
endmodule

bind irq_aggregator irq_aggregator_chk #(.NSRC(NSRC), .LVLW(LVLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .gie(gie), .cpu_level(cpu_level), .ack(ack),
  .req(req), .cpu_irq(cpu_irq), .pend(pend), .mask(mask), .lvl(lvl)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
  logic       clk = 0, rst_n = 0;
  logic [7:0] evt = 0, bus_wdata = 0, bus_rdata;
  logic [1:0] bus_addr = 0;
  logic       bus_wr = 0, gie = 0, ack = 0, req, cpu_irq;
  logic [2:0] cpu_level = 0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_aggregator dut (.clk(clk), .rst_n(rst_n), .evt(evt), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie),
    .cpu_level(cpu_level), .ack(ack), .req(req), .cpu_irq(cpu_irq));

  // {mask[31:24], evt[23:16], 3'b0,gie,1'b0,lvl[10:8], 1'b0,cpu_level[6:4],2'b0,exp_req,exp_irq}
  localparam logic [31:0] VEC [8] = '{
    32'h0101_1303, 32'h0102_1300, 32'hF010_0512, 32'h8080_1222,
    32'h8080_1002, 32'hFFA5_1763, 32'h00FF_1700, 32'h3CC3_1430 };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [7:0] e = 0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1; evt = e;
    @(negedge clk);
    bus_wr = 0; evt = 0;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  initial begin
    #500us;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, d); chk("R9 pend", d, 0);
    rd(1, d); chk("R9 mask", d, 0);
    rd(2, d); chk("R9 ctrl", d, 0);
    chk("R9 irq", {req, cpu_irq}, 0);

    foreach (VEC[i]) begin
      wr(0, 8'h00);
      wr(1, VEC[i][31:24]);
      wr(2, {5'b0, VEC[i][10:8]});
      gie = VEC[i][12]; cpu_level = VEC[i][6:4];
      pulse(VEC[i][23:16]);
      rd(0, d); chk("R10 pend readback", d, VEC[i][23:16]);
      chk(VEC[i][1] ? "R1 req" : "R2 req", req, VEC[i][1]);
      chk("R7 cpu_irq", cpu_irq, VEC[i][0]);
    end

    // R3: control bit 3 write ignored
    wr(0, 8'h00); wr(1, 8'h01); gie = 1; cpu_level = 0;
    pulse(8'h01);
    wr(2, 8'h04);
    rd(2, d); chk("R3 ctrl", d, 8'h0C);
    chk("R3 req", req, 1);

    // R4, R5: ack has no effect
    @(negedge clk); ack = 1;
    repeat (3) @(negedge clk);
    ack = 0;
    rd(0, d); chk("R4 pend after ack", d, 8'h01);
    chk("R5 req after ack", req, 1);

    // R6: second source while high, sampled every cycle
    wr(1, 8'h03);
    @(negedge clk); evt = 8'h02;
    chk("R6 req c0", req, 1);
    @(negedge clk); evt = 0;
    chk("R6 req c1", req, 1);
    @(negedge clk);
    chk("R6 req c2", req, 1);
    rd(0, d); chk("R6 pend", d, 8'h03);

    // R8: clear semantics
    wr(0, 8'hFE);
    rd(0, d); chk("R8 clear bit0", d, 8'h02);
    chk("R2 req still from bit1", req, 1);
    wr(0, 8'hFF);
    rd(0, d); chk("R8 write1 no change", d, 8'h02);
    wr(0, 8'h00, 8'h02);
    rd(0, d); chk("R8 event wins", d, 8'h02);
    wr(0, 8'h00);
    rd(0, d); chk("R8 all clear", d, 8'h00);
    chk("R2 req drops at once", req, 0);

    // R9: reset mid-run
    wr(2, 8'h07); pulse(8'hFF);
    chk("R1 req before reset", req, 1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(0, d); chk("R9 pend after reset", d, 0);
    rd(2, d); chk("R9 ctrl after reset", d, 0);
    chk("R9 irq after reset", cpu_irq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule